// File: doc/BRIEF.md
# Smart Card Character Receiver with Retry

This block recovers characters from the half-duplex, open-drain I/O line of a contact card. It uses a half-ETU strobe from an external divider. A falling line seen at one strobe is confirmed by the next strobe. After that, one bit is sampled every second strobe: eight data bits, a parity bit and the first stop ETU. The block delivers the byte with a one-cycle valid pulse. It keeps sticky error flags that are cleared by writing 1.

Two bit conventions are supported. Direct convention takes line levels as they are, LSB first. Inverse convention inverts the levels and takes the byte MSB first. When automatic convention is on, the first character received is treated as the initial TS byte and selects the convention by itself. With retry enabled, a parity error is not flagged. The receiver instead pulls the line low for one ETU, which asks the sender to repeat the character, and it counts these requests against a programmable limit.

Top module: `sc_char_rx`

## Requirements
- R1: After reset, `rx_valid_o` and `err_drive_o` are 0, `flags_o` is 0, and `conv_o` shows the configured code while automatic convention is off.
- R2: In direct convention a character is accepted as follows. The start bit is low, the data bits are taken LSB first at their line levels, and the parity is even over data and parity. `rx_valid_o` then pulses for exactly one cycle with the byte on `rx_data_o`, one cycle after the first stop ETU is sampled.
- R3: Convention code 2'b11 selects inverse convention, in which levels are inverted and the data comes MSB first. Codes 2'b00, 2'b01 and 2'b10 all act as direct convention.
- R4: With retry off, a parity mismatch sets `flags_o[0]`, and the byte is still delivered.
- R5: With retry off, a low first stop ETU sets `flags_o[1]`, and the byte is still delivered.
- R6: With retry off, `flags_o[2]` (break) is set when the line stays low longer than a full character of 10 + stop ETUs. A stop length of 1 ETU applies when `stop_one_i` is 1, and 2 ETUs otherwise. A 12-ETU low therefore breaks with one stop ETU but not with two.
- R7: With retry on, a parity mismatch drives `err_drive_o` high for exactly one ETU (two strobes). The drive starts at the first strobe after the parity sample. The character is not delivered, `flags_o[3]` is set and `flags_o[0]` stays 0.
- R8: The retry limit is `retry_lim_i` + 1 consecutive signalled errors. The next parity error after the limit sets `flags_o[4]`, is not signalled and is not delivered, and the count restarts. A good character also restarts the count.
- R9: With retry on, frame and break conditions never set `flags_o[1]` or `flags_o[2]`.
- R10: When `auto_conv_i` is 1, the first character after it rises (or after reset) is TS. If its levels read direct as 0x3B, direct convention (`conv_o` = 2'b00) is selected. If they read inverse as 0x3F, inverse convention (`conv_o` = 2'b11) is selected. While `auto_conv_i` is 1, the configured code is ignored.
- R11: A TS byte that matches neither pattern sets `flags_o[5]` and leaves the selected convention unchanged.
- R12: The flags are sticky. A 1 on bit k of `flag_clr_i` clears `flags_o[k]` and leaves the other bits alone. A set in the same cycle wins over the clear.
- R13: A low level seen at one strobe but high at the next strobe is discarded as a glitch, and no character results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_etu_i | input | 1 | One-cycle strobe, two per ETU |
| line_i | input | 1 | Resolved card I/O line level |
| cfg_conv_i | input | 2 | Configured convention, 2'b11 inverse |
| auto_conv_i | input | 1 | Automatic convention from TS |
| retry_en_i | input | 1 | Parity-error retry signalling enable |
| retry_lim_i | input | 3 | Retry limit minus one |
| stop_one_i | input | 1 | 1: one stop ETU, 0: two |
| flag_clr_i | input | 6 | Write-1-to-clear for flags_o |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | One-cycle byte strobe |
| err_drive_o | output | 1 | Request to pull the line low |
| flags_o | output | 6 | [0] parity, [1] frame, [2] break, [3] retry, [4] over-retry, [5] TS error |
| conv_o | output | 2 | Convention in use |

## Verification
A bit counter that slips shows up on the next character: the byte arrives shifted or the frame flag appears, about one ETU after the stop sample. A wrong retry count is exposed on the first parity error beyond the limit, when the over-retry flag appears either one character early or one late. An error in the convention register shows on `conv_o` one cycle after the TS parity sample, and every later byte comes out mirrored and inverted. Misplaced drive timing is caught by measuring the phase at which `err_drive_o` rises and its width in clock cycles.

// File: rtl/sc_char_rx.sv
module sc_char_rx #(
  parameter int RTY_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             half_etu_i,
  input  logic             line_i,
  input  logic [1:0]       cfg_conv_i,
  input  logic             auto_conv_i,
  input  logic             retry_en_i,
  input  logic [RTY_W-1:0] retry_lim_i,
  input  logic             stop_one_i,
  input  logic [5:0]       flag_clr_i,
  output logic [7:0]       rx_data_o,
  output logic             rx_valid_o,
  output logic             err_drive_o,
  output logic [5:0]       flags_o,
  output logic [1:0]       conv_o
);
  localparam int CNT_W    = RTY_W + 1;
  localparam int CHAR_ETU = 10;
  localparam int THR_1    = 2 * (CHAR_ETU + 1) + 1;
  localparam int THR_2    = 2 * (CHAR_ETU + 2) + 1;
  localparam int LOW_W    = $clog2(THR_2 + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_SIG, S_REARM} st_t;

  st_t             st;
  logic            ph, hold_ok, learned_inv, ts_seen;
  logic [2:0]      idx;
  logic [1:0]      sigc;
  logic [7:0]      raw, rev_raw, byte_dec;
  logic [CNT_W-1:0] rcnt, lim;
  logic [LOW_W-1:0] lowc, thr;

  always_comb
    for (int i = 0; i < 8; i++) rev_raw[i] = raw[7-i];

  logic cfg_inv, ts_pend, ts_dir, ts_inv, use_inv, par_bad, par_smp, stop_smp;
  logic do_sig, over;
  logic [5:0] set_v;

  assign cfg_inv  = (cfg_conv_i == 2'b11);
  assign ts_pend  = auto_conv_i & ~ts_seen;
  assign ts_dir   = (raw == 8'h3B);
  assign ts_inv   = (~rev_raw == 8'h3F);
  assign use_inv  = ts_pend ? (ts_dir ? 1'b0 : (ts_inv ? 1'b1 : learned_inv))
                            : (auto_conv_i ? learned_inv : cfg_inv);
  assign byte_dec = use_inv ? ~rev_raw : raw;
  assign par_bad  = (^raw) ^ line_i ^ use_inv;
  assign lim      = {1'b0, retry_lim_i} + CNT_W'(1);
  assign par_smp  = half_etu_i & ph & (st == S_PAR);
  assign stop_smp = half_etu_i & ph & (st == S_STOP);
  assign do_sig   = retry_en_i & par_bad & (rcnt < lim);
  assign over     = retry_en_i & par_bad & ~(rcnt < lim);
  assign thr      = stop_one_i ? LOW_W'(THR_1) : LOW_W'(THR_2);

  assign set_v[0] = par_smp & par_bad & ~retry_en_i;
  assign set_v[1] = stop_smp & ~line_i & ~retry_en_i;
  assign set_v[2] = half_etu_i & ~line_i & ~err_drive_o & (lowc == thr - LOW_W'(1)) & ~retry_en_i;
  assign set_v[3] = par_smp & do_sig;
  assign set_v[4] = par_smp & over;
  assign set_v[5] = par_smp & ts_pend & ~ts_dir & ~ts_inv;

  assign conv_o = auto_conv_i ? {2{learned_inv}} : cfg_conv_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_o <= '0;
      lowc    <= '0;
    end else begin
      flags_o <= (flags_o & ~flag_clr_i) | set_v;
      if (half_etu_i) begin
        if (line_i || err_drive_o) lowc <= '0;
        else if (lowc < thr)       lowc <= lowc + LOW_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      learned_inv <= 1'b0;
      ts_seen     <= 1'b0;
    end else begin
      if (!auto_conv_i) ts_seen <= 1'b0;
      else if (par_smp && ts_pend && !do_sig) ts_seen <= 1'b1;
      if (par_smp && ts_pend) begin
        if (ts_dir)      learned_inv <= 1'b0;
        else if (ts_inv) learned_inv <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      ph          <= 1'b0;
      idx         <= '0;
      sigc        <= '0;
      raw         <= '0;
      rcnt        <= '0;
      hold_ok     <= 1'b0;
      rx_data_o   <= '0;
      rx_valid_o  <= 1'b0;
      err_drive_o <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      if (half_etu_i) begin
        unique case (st)
          S_IDLE:  if (!line_i) st <= S_START;
          S_START: begin
            ph  <= 1'b0;
            idx <= '0;
            st  <= line_i ? S_IDLE : S_DATA;
          end
          S_DATA: begin
            ph <= ~ph;
            if (ph) begin
              raw <= {line_i, raw[7:1]};
              idx <= idx + 3'd1;
              if (idx == 3'd7) st <= S_PAR;
            end
          end
          S_PAR: begin
            ph <= ~ph;
            if (ph) begin
              rx_data_o <= byte_dec;
              hold_ok   <= ~(retry_en_i & par_bad);
              if (do_sig)                 rcnt <= rcnt + CNT_W'(1);
              else if (over || !par_bad)  rcnt <= '0;
              sigc <= '0;
              st   <= do_sig ? S_SIG : S_STOP;
            end
          end
          S_STOP: begin
            ph <= ~ph;
            if (ph) begin
              rx_valid_o <= hold_ok;
              st         <= S_REARM;
            end
          end
          S_SIG: begin
            sigc <= sigc + 2'd1;
            if (sigc == 2'd0) err_drive_o <= 1'b1;
            if (sigc == 2'd2) begin
              err_drive_o <= 1'b0;
              st          <= S_REARM;
            end
          end
          S_REARM: if (line_i) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);
  assert_no_valid_in_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_drive_o |-> !rx_valid_o);
  assert_drive_ends_on_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_drive_o) |-> $past(half_etu_i));
  assert_no_parity_flag_retry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_o[0]) |-> !$past(retry_en_i));
  assert_no_frame_flag_retry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_o[1]) |-> !$past(retry_en_i));
  assert_no_break_flag_retry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_o[2]) |-> !$past(retry_en_i));
  assert_over_retry_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_o[4]) |-> !err_drive_o);
  assert_learned_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    auto_conv_i |-> (conv_o == 2'b00 || conv_o == 2'b11));
endmodule

// File: tb/sc_char_rx_tb.sv
module sc_char_rx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [31:0] cyc = '0;
  logic       line_drv = 1'b1;
  logic [1:0] cfg_conv = 2'b00;
  logic       auto_conv = 1'b0, retry_en = 1'b0, stop_one = 1'b0;
  logic [2:0] retry_lim = 3'd0;
  logic [5:0] flag_clr = '0;
  logic [7:0] rx_data;
  logic       rx_valid, err_drive, half_etu, line;
  logic [5:0] flags;
  logic [1:0] conv;

  int nchk = 0, nfail = 0, nvalid = 0, ndrive = 0;
  logic [7:0] last_data = '0;
  logic [2:0] rise_ph = '0;
  logic       drv_prev = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign half_etu = (cyc[1:0] == 2'b00);
  assign line = line_drv & ~err_drive;

  sc_char_rx u_dut (
    .clk(clk), .rst_n(rst_n), .half_etu_i(half_etu), .line_i(line),
    .cfg_conv_i(cfg_conv), .auto_conv_i(auto_conv), .retry_en_i(retry_en),
    .retry_lim_i(retry_lim), .stop_one_i(stop_one), .flag_clr_i(flag_clr),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .err_drive_o(err_drive),
    .flags_o(flags), .conv_o(conv));

  always @(negedge clk) begin
    if (rx_valid) begin nvalid = nvalid + 1; last_data = rx_data; end
    if (err_drive) begin
      ndrive = ndrive + 1;
      if (!drv_prev) rise_ph = cyc[2:0];
    end
    drv_prev = err_drive;
  end

  task automatic check(input string req, input int got, input int exp);
    nchk++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic etu(input logic lvl);
    do @(negedge clk); while (cyc[2:0] != 3'd2);
    line_drv = lvl;
  endtask

  task automatic send_char(input logic [7:0] b, input logic inv, input logic bad, input logic stop_lvl);
    logic lb, p;
    etu(1'b0);
    for (int i = 0; i < 8; i++) begin
      lb = inv ? b[7-i] : b[i];
      etu(inv ? ~lb : lb);
    end
    p = (^b) ^ bad;
    etu(inv ? ~p : p);
    etu(stop_lvl);
    etu(1'b1);
    repeat (3) etu(1'b1);
  endtask

  task automatic hold_low(input int n);
    for (int i = 0; i < n; i++) etu(1'b0);
    repeat (4) etu(1'b1);
  endtask

  task automatic clear_all();
    @(negedge clk); flag_clr = 6'h3F;
    @(negedge clk); flag_clr = 6'h00;
  endtask

  // {convention code, corrupt parity, byte, expected parity flag}
  localparam logic [11:0] VEC [7] = '{
    {2'b00, 1'b0, 8'hA5, 1'b0},
    {2'b00, 1'b1, 8'h3C, 1'b1},
    {2'b11, 1'b0, 8'h5A, 1'b0},
    {2'b11, 1'b1, 8'hC3, 1'b1},
    {2'b01, 1'b0, 8'h81, 1'b0},
    {2'b10, 1'b0, 8'h7E, 1'b0},
    {2'b11, 1'b0, 8'h01, 1'b0}
  };

  logic done = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int v0, d0;
    repeat (5) @(negedge clk);
    check("R1 valid", rx_valid, 0);
    check("R1 drive", err_drive, 0);
    check("R1 flags", flags, 0);
    check("R1 conv", conv, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    cfg_conv = 2'b11;
    @(negedge clk);
    check("R1 conv follows cfg", conv, 3);

    for (int i = 0; i < 7; i++) begin
      logic [11:0] v;
      v = VEC[i];
      clear_all();
      cfg_conv = v[11:10];
      v0 = nvalid;
      send_char(v[8:1], v[11:10] == 2'b11, v[9], 1'b1);
      check("R2 one valid per char", nvalid - v0, 1);
      check("R2/R3 data", last_data, v[8:1]);
      check("R4 parity flag", flags[0], v[0]);
    end

    cfg_conv = 2'b00;
    clear_all();
    v0 = nvalid;
    etu(1'b0);
    repeat (3) @(negedge clk);
    line_drv = 1'b1;
    repeat (6) etu(1'b1);
    check("R13 glitch ignored", nvalid - v0, 0);
    check("R13 no flags", flags, 0);

    v0 = nvalid;
    send_char(8'h55, 1'b0, 1'b0, 1'b0);
    check("R5 frame flag", flags[1], 1);
    check("R5 still delivered", nvalid - v0, 1);
    check("R5 data", last_data, 8'h55);

    clear_all();
    stop_one = 1'b1;
    hold_low(12);
    check("R6 break one stop 12 ETU", flags[2], 1);
    clear_all();
    stop_one = 1'b0;
    hold_low(12);
    check("R6 no break two stop 12 ETU", flags[2], 0);
    check("R5 frame on long low", flags[1], 1);
    hold_low(13);
    check("R6 break two stop 13 ETU", flags[2], 1);

    @(negedge clk); flag_clr = 6'b000010;
    @(negedge clk); flag_clr = 6'b000000;
    check("R12 selective clear", flags, 6'b000100);
    clear_all();
    check("R12 clear all", flags, 0);

    retry_en = 1'b1; retry_lim = 3'd0;
    v0 = nvalid; d0 = ndrive;
    send_char(8'h96, 1'b0, 1'b1, 1'b1);
    check("R7 drive one ETU", ndrive - d0, 8);
    check("R7 drive phase", rise_ph, 5);
    check("R7 not delivered", nvalid - v0, 0);
    check("R7 retry flag", flags[3], 1);
    check("R7 no parity flag", flags[0], 0);
    d0 = ndrive;
    send_char(8'h96, 1'b0, 1'b1, 1'b1);
    check("R8 over-retry flag", flags[4], 1);
    check("R8 no drive past limit", ndrive - d0, 0);
    check("R8 not delivered", nvalid - v0, 0);
    send_char(8'h96, 1'b0, 1'b0, 1'b1);
    check("R8 good char after", nvalid - v0, 1);
    check("R8 data", last_data, 8'h96);

    clear_all();
    retry_lim = 3'd1;
    d0 = ndrive;
    send_char(8'h2D, 1'b0, 1'b1, 1'b1);
    send_char(8'h2D, 1'b0, 1'b1, 1'b1);
    check("R8 two retries signalled", ndrive - d0, 16);
    check("R8 no over yet", flags[4], 0);
    send_char(8'h2D, 1'b0, 1'b1, 1'b1);
    check("R8 over at third", flags[4], 1);

    clear_all();
    hold_low(14);
    check("R9 no frame in retry", flags[1], 0);
    check("R9 no break in retry", flags[2], 0);

    retry_en = 1'b0;
    clear_all();
    cfg_conv = 2'b00; auto_conv = 1'b1;
    send_char(8'h3F, 1'b1, 1'b0, 1'b1);
    check("R10 TS inverse conv", conv, 3);
    check("R10 TS data", last_data, 8'h3F);
    send_char(8'h5A, 1'b1, 1'b0, 1'b1);
    check("R10 cfg ignored", last_data, 8'h5A);
    @(negedge clk); auto_conv = 1'b0;
    repeat (2) @(negedge clk); auto_conv = 1'b1;
    send_char(8'h12, 1'b0, 1'b0, 1'b1);
    check("R11 TS error flag", flags[5], 1);
    check("R11 conv kept", conv, 3);
    @(negedge clk); auto_conv = 1'b0;
    repeat (2) @(negedge clk); auto_conv = 1'b1;
    clear_all();
    send_char(8'h3B, 1'b0, 1'b0, 1'b1);
    check("R10 TS direct conv", conv, 0);
    check("R10 TS direct data", last_data, 8'h3B);
    check("R11 no error on valid TS", flags[5], 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule